// File: doc/BRIEF.md
# Pausable Program-and-Verify Line Controller

This controller writes one line of multi-level cells by looping over iterations. Each iteration sends a program pulse, senses the cells back, and compares every cell against its target level. Cells that match are retired into a sticky mask and receive no more pulses. The line is finished once the last cell has matched, so the number of iterations equals what the slowest cell needs. If a ceiling on the iteration count is reached before every cell matches, the controller stops and flags an error.

Reads that arrive during a write are serviced at iteration boundaries. After a verify step the controller enters a paused state and grants pending reads, up to a configurable number per pause, then resumes the write. When cancellation is enabled, a read that arrives while a pulse is running aborts only that pulse. The read is served, and then that same iteration runs again from its start, keeping all iterations already completed. A forced-mode input turns off both pausing and cancellation, so a write that must drain runs straight to the end.

Top module: `pgm_verify_ctrl`

## Requirements
- R1: An iteration is a program pulse held for PULSE_CYC cycles on `cell_prog`, then one cycle of `cell_sense`, then a compare cycle. Iterations repeat until every cell's read-back equals its target. The number of sense cycles for a line equals the largest target level among its cells, or 1 when every target is 0, given cells that start at level 0 and rise one level per complete pulse.
- R2: `cell_mask` bit i is 1 only for cells not yet matched. A matched cell receives no further pulses. The mask is held unchanged while paused. Cell i's target occupies bits [i*LVL_W +: LVL_W] of `wr_data` and `cell_wdata`.
- R3: With forced mode low, a read pending in the compare cycle of an unfinished iteration puts the controller into the paused state (`paused`=1), where `rd_grant` follows `rd_req`. During a write, reads are granted only while paused.
- R4: One pause grants at most RD_CAP reads. The controller leaves the pause when `rd_req` drops or the cap is reached, and any remaining reads are served at later pauses.
- R5: With `cancel_en`=1 and forced mode low, a read seen during any pulse cycle except the last one ends the pulse early and enters the paused state. The same iteration is then started again. The count of completed iterations and the levels reached are unaffected.
- R6: While `forced_mode`=1, the controller neither pauses nor cancels. No read is granted until the line finishes.
- R7: If MAX_ITER iterations complete without every cell matching, `wr_done` and `wr_err` both rise. `wr_err` stays 0 for a line that finishes normally.
- R8: When no write is in progress, `rd_grant` follows `rd_req` on every cycle in which `wr_start` is low.
- R9: After reset, `cell_prog`, `cell_sense`, `paused`, `wr_done`, `wr_err` and `rd_grant` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_start | input | 1 | One-cycle request that starts a line write; accepted only when no write is in progress |
| wr_data | input | CELLS*LVL_W | Target level of every cell, captured on start |
| forced_mode | input | 1 | Disables pausing and cancellation |
| cancel_en | input | 1 | Allows a pending read to abort the running pulse |
| rd_req | input | 1 | At least one read is waiting |
| rd_grant | output | 1 | The read at the head of the queue is served in this cycle |
| cell_prog | output | 1 | Program pulse to the cell array |
| cell_sense | output | 1 | Read-back strobe to the cell array |
| cell_mask | output | CELLS | Cells that take part in the pulse |
| cell_wdata | output | CELLS*LVL_W | Target levels driven to the cells |
| cell_rdata | input | CELLS*LVL_W | Read-back levels, valid in the cycle after `cell_sense` |
| paused | output | 1 | Write suspended at a pause point while reads are served |
| wr_done | output | 1 | Line finished; held until the next start |
| wr_err | output | 1 | Line finished without every cell matching; held until the next start |

## Verification
On every cycle, the assertions check the order of the iteration steps, the stability of the match mask across a pause, the per-pause read cap, the absence of read grants during a pulse or sense cycle, the rule that a pause is never entered under forced mode, and the bound on the iteration count. Only the bench's scenarios can show the end-to-end behaviour: that the iteration count follows the slowest cell, that an aborted pulse leaves the cells' levels untouched and adds exactly one extra pulse start, that queued reads are all served across several pauses, and that a stuck cell ends in the error flag.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_SENSE,
    ST_CMP,
    ST_SERVE
  } pvc_state_e;
endpackage

// File: rtl/pvc_cell_cmp.sv
module pvc_cell_cmp #(
  parameter int CELLS = 4,
  parameter int LVL_W = 3
) (
  input  logic [CELLS*LVL_W-1:0] tgt,
  input  logic [CELLS*LVL_W-1:0] sensed,
  output logic [CELLS-1:0]       hit
);
  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    assign hit[g] = (sensed[g*LVL_W +: LVL_W] == tgt[g*LVL_W +: LVL_W]);
  end
endmodule

// File: rtl/pvc_seq.sv
module pvc_seq
  import pvc_pkg::*;
#(
  parameter int CELLS     = 4,
  parameter int MAX_ITER  = 16,
  parameter int PULSE_CYC = 4,
  parameter int RD_CAP    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             forced_mode,
  input  logic             cancel_en,
  input  logic             rd_req,
  input  logic [CELLS-1:0] hit,
  output logic             load,
  output logic             rd_grant,
  output logic             cell_prog,
  output logic             cell_sense,
  output logic [CELLS-1:0] cell_mask,
  output logic             paused,
  output logic             wr_done,
  output logic             wr_err
);
  localparam int IW = $clog2(MAX_ITER + 1);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam int CW = $clog2(RD_CAP + 1);
  localparam logic [PW-1:0] PLAST = PW'(PULSE_CYC - 1);
  localparam logic [IW-1:0] ILAST = IW'(MAX_ITER - 1);
  localparam logic [CW-1:0] CLAST = CW'(RD_CAP - 1);

  pvc_state_e       st_q, st_d;
  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic [IW-1:0]    iter_q, iter_d;
  logic [CW-1:0]    rdn_q, rdn_d;
  logic [CELLS-1:0] dmask_q, dmask_d;
  logic             done_q, done_d, err_q, err_d;
  logic             all_ok, may_break;

  assign all_ok    = &(dmask_q | hit);
  assign may_break = rd_req && !forced_mode;

  always_comb begin
    st_d       = st_q;
    pcnt_d     = pcnt_q;
    iter_d     = iter_q;
    rdn_d      = rdn_q;
    dmask_d    = dmask_q;
    done_d     = done_q;
    err_d      = err_q;
    load       = 1'b0;
    rd_grant   = 1'b0;
    cell_prog  = 1'b0;
    cell_sense = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        rd_grant = rd_req && !wr_start;
        if (wr_start) begin
          load    = 1'b1;
          dmask_d = '0;
          iter_d  = '0;
          pcnt_d  = '0;
          done_d  = 1'b0;
          err_d   = 1'b0;
          st_d    = ST_PROG;
        end
      end
      ST_PROG: begin
        cell_prog = 1'b1;
        if (pcnt_q != PLAST && may_break && cancel_en) begin
          pcnt_d = '0;
          rdn_d  = '0;
          st_d   = ST_SERVE;
        end else if (pcnt_q == PLAST) begin
          pcnt_d = '0;
          st_d   = ST_SENSE;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
      ST_SENSE: begin
        cell_sense = 1'b1;
        st_d       = ST_CMP;
      end
      ST_CMP: begin
        dmask_d = dmask_q | hit;
        iter_d  = iter_q + 1'b1;
        if (all_ok) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (iter_q == ILAST) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = ST_IDLE;
        end else if (may_break) begin
          rdn_d = '0;
          st_d  = ST_SERVE;
        end else begin
          st_d = ST_PROG;
        end
      end
      ST_SERVE: begin
        rd_grant = rd_req;
        if (rd_req) rdn_d = rdn_q + 1'b1;
        if (!rd_req || rdn_q == CLAST) st_d = ST_PROG;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pcnt_q  <= '0;
      iter_q  <= '0;
      rdn_q   <= '0;
      dmask_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      pcnt_q  <= pcnt_d;
      iter_q  <= iter_d;
      rdn_q   <= rdn_d;
      dmask_q <= dmask_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign cell_mask = ~dmask_q;
  assign paused    = (st_q == ST_SERVE);
  assign wr_done   = done_q;
  assign wr_err    = err_q;

  // R1: a pulse ends either in a sense cycle or in a cancel-pause
  a_r1_pulse_then_sense: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cell_prog) |-> (cell_sense || paused));
  // R2: pulses always address at least one unmatched cell
  a_r2_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
    cell_prog |-> (cell_mask != '0));
  // R2: match mask frozen while paused
  a_r2_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && $past(paused)) |-> $stable(dmask_q));
  // R3: no grant during pulse or sense
  a_r3_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> (!cell_prog && !cell_sense));
  // R4: per-pause grant cap
  a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && rd_grant) |-> (rdn_q < CW'(RD_CAP)));
  // R6: no pause entered while forced
  a_r6_forced_no_pause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(forced_mode));
  // R7: iteration count bounded
  a_r7_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= IW'(MAX_ITER));
endmodule

// File: rtl/pgm_verify_ctrl.sv
module pgm_verify_ctrl #(
  parameter int CELLS     = 4,
  parameter int LVL_W     = 3,
  parameter int MAX_ITER  = 16,
  parameter int PULSE_CYC = 4,
  parameter int RD_CAP    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_start,
  input  logic [CELLS*LVL_W-1:0] wr_data,
  input  logic                   forced_mode,
  input  logic                   cancel_en,
  input  logic                   rd_req,
  output logic                   rd_grant,
  output logic                   cell_prog,
  output logic                   cell_sense,
  output logic [CELLS-1:0]       cell_mask,
  output logic [CELLS*LVL_W-1:0] cell_wdata,
  input  logic [CELLS*LVL_W-1:0] cell_rdata,
  output logic                   paused,
  output logic                   wr_done,
  output logic                   wr_err
);
  localparam int DW = CELLS * LVL_W;

  logic          rst_meta, rst_sync;
  logic          load;
  logic [DW-1:0] tgt_q;
  logic [CELLS-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) tgt_q <= '0;
    else if (load) tgt_q <= wr_data;
  end

  assign cell_wdata = tgt_q;

  pvc_cell_cmp #(.CELLS(CELLS), .LVL_W(LVL_W)) i_cmp (
    .tgt    (tgt_q),
    .sensed (cell_rdata),
    .hit    (hit)
  );

  pvc_seq #(
    .CELLS(CELLS), .MAX_ITER(MAX_ITER), .PULSE_CYC(PULSE_CYC), .RD_CAP(RD_CAP)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_sync),
    .wr_start    (wr_start),
    .forced_mode (forced_mode),
    .cancel_en   (cancel_en),
    .rd_req      (rd_req),
    .hit         (hit),
    .load        (load),
    .rd_grant    (rd_grant),
    .cell_prog   (cell_prog),
    .cell_sense  (cell_sense),
    .cell_mask   (cell_mask),
    .paused      (paused),
    .wr_done     (wr_done),
    .wr_err      (wr_err)
  );
endmodule

// File: tb/test_pgm_verify_ctrl.sv
module test_pgm_verify_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS = 4, LVL_W = 3, MAX_ITER = 16, PULSE_CYC = 4, RD_CAP = 2;
  localparam int DW = CELLS * LVL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 1'b0, forced_mode = 1'b0, cancel_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] cell_rdata = '0;
  logic rd_req, rd_grant, cell_prog, cell_sense, paused, wr_done, wr_err;
  logic [CELLS-1:0] cell_mask;
  logic [DW-1:0] cell_wdata;

  int n_chk = 0, n_bad = 0;

  // behavioural cell array and read host
  int lvl [CELLS];
  int pulses [CELLS];
  logic [CELLS-1:0] stuck = '0;
  int run = 0, rises = 0, senses = 0, pauses = 0, cur_g = 0, max_g = 0;
  int g_out = 0, pend = 0, push = 0;
  logic prog_q = 1'b0, paused_q = 1'b0, in_write = 1'b0;

  assign rd_req = (pend > 0);

  always #(CLK_PERIOD/2) clk = ~clk;

  pgm_verify_ctrl #(
    .CELLS(CELLS), .LVL_W(LVL_W), .MAX_ITER(MAX_ITER),
    .PULSE_CYC(PULSE_CYC), .RD_CAP(RD_CAP)
  ) i_pgm_verify_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_data(wr_data),
    .forced_mode(forced_mode), .cancel_en(cancel_en), .rd_req(rd_req),
    .rd_grant(rd_grant), .cell_prog(cell_prog), .cell_sense(cell_sense),
    .cell_mask(cell_mask), .cell_wdata(cell_wdata), .cell_rdata(cell_rdata),
    .paused(paused), .wr_done(wr_done), .wr_err(wr_err)
  );

  always @(posedge clk) begin
    if (wr_done) in_write = 1'b0;
    if (wr_start) begin
      in_write = 1'b1;
      for (int i = 0; i < CELLS; i++) begin lvl[i] = 0; pulses[i] = 0; end
      rises = 0; senses = 0; pauses = 0; cur_g = 0; max_g = 0; g_out = 0;
    end
    if (cell_prog) begin
      if (!prog_q) rises++;
      run++;
      if (run == PULSE_CYC) begin
        for (int i = 0; i < CELLS; i++) if (cell_mask[i]) begin
          pulses[i]++;
          if (!stuck[i] && lvl[i] < int'(cell_wdata[i*LVL_W +: LVL_W])) lvl[i]++;
        end
      end
    end else run = 0;
    prog_q = cell_prog;
    if (cell_sense) begin
      senses++;
      for (int i = 0; i < CELLS; i++) cell_rdata[i*LVL_W +: LVL_W] <= LVL_W'(lvl[i]);
    end
    if (paused && !paused_q) pauses++;
    if (rd_req && rd_grant) begin
      if (paused) cur_g++;
      else if (in_write) g_out++;
    end
    if (!paused && paused_q) begin
      if (cur_g > max_g) max_g = cur_g;
      cur_g = 0;
    end
    paused_q = paused;
    pend = pend + push - ((rd_req && rd_grant) ? 1 : 0);
  end

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic push_rd(input int n);
    @(negedge clk) push = n;
    @(negedge clk) push = 0;
  endtask

  task automatic start_wr(input logic [DW-1:0] d);
    @(negedge clk);
    wr_data = d; wr_start = 1'b1;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!wr_done && t < 5000) begin @(negedge clk); t++; end
    if (!wr_done) chk(0, 1, {tag, " line finished"});
  endtask

  task automatic wait_quiet();
    int t = 0;
    while (pend != 0 && t < 200) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pack4(input int a, b, c, d);
    logic [DW-1:0] v;
    v = '0;
    v[0*LVL_W +: LVL_W] = LVL_W'(a);
    v[1*LVL_W +: LVL_W] = LVL_W'(b);
    v[2*LVL_W +: LVL_W] = LVL_W'(c);
    v[3*LVL_W +: LVL_W] = LVL_W'(d);
    return v;
  endfunction

  task automatic t_reset();
    chk(int'(cell_prog), 0, "R9 cell_prog after reset");
    chk(int'(cell_sense), 0, "R9 cell_sense after reset");
    chk(int'(paused), 0, "R9 paused after reset");
    chk(int'(wr_done), 0, "R9 wr_done after reset");
    chk(int'(wr_err), 0, "R9 wr_err after reset");
    chk(int'(rd_grant), 0, "R9 rd_grant after reset");
  endtask

  task automatic t_basic();
    start_wr(pack4(7, 3, 0, 5));
    wait_done("R1 basic");
    chk(senses, 7, "R1 iterations follow slowest cell");
    chk(int'(wr_err), 0, "R7 no error on normal finish");
    chk(pulses[0], 7, "R2 pulses cell0");
    chk(pulses[1], 3, "R2 pulses cell1 stop after match");
    chk(pulses[2], 1, "R2 pulses cell2 target zero");
    chk(pulses[3], 5, "R2 pulses cell3");
    chk(rises, 7, "R1 one pulse per iteration");
  endtask

  task automatic t_zero();
    start_wr(pack4(0, 0, 0, 0));
    wait_done("R1 zero");
    chk(senses, 1, "R1 all-zero line one iteration");
    chk(int'(wr_err), 0, "R7 all-zero no error");
  endtask

  task automatic t_pause();
    cancel_en = 1'b0;
    start_wr(pack4(6, 6, 2, 1));
    while (senses < 2) @(negedge clk);
    push_rd(1);
    wait_done("R3 pause");
    wait_quiet();
    chk(pauses, 1, "R3 one pause taken");
    chk(g_out, 0, "R3 no grant outside pause");
    chk(pend, 0, "R3 read served");
    chk(rises, senses, "R3 no cancellation without cancel_en");
    chk(senses, 6, "R3 iterations unchanged by pause");
  endtask

  task automatic t_cap();
    cancel_en = 1'b0;
    start_wr(pack4(7, 7, 7, 7));
    while (senses < 1) @(negedge clk);
    push_rd(5);
    wait_done("R4 cap");
    wait_quiet();
    chk(int'(max_g <= RD_CAP), 1, "R4 grants per pause within cap");
    chk(pauses, 3, "R4 five reads need three pauses");
    chk(pend, 0, "R4 all queued reads served");
    chk(g_out, 0, "R4 no grant outside pause");
  endtask

  task automatic t_cancel();
    cancel_en = 1'b1;
    start_wr(pack4(7, 4, 2, 6));
    while (!(senses == 3 && cell_prog)) @(negedge clk);
    push = 1;
    @(negedge clk) push = 0;
    wait_done("R5 cancel");
    wait_quiet();
    chk(senses, 7, "R5 completed iterations kept");
    chk(rises, 8, "R5 one extra pulse start from micro-cancel");
    chk(pulses[0], 7, "R5 aborted pulse not applied cell0");
    chk(pulses[1], 4, "R5 aborted pulse not applied cell1");
    chk(pauses, 1, "R5 cancel enters pause");
    chk(pend, 0, "R5 read served");
    cancel_en = 1'b0;
  endtask

  task automatic t_forced();
    forced_mode = 1'b1; cancel_en = 1'b1;
    start_wr(pack4(5, 5, 5, 5));
    push_rd(2);
    wait_done("R6 forced");
    chk(pauses, 0, "R6 no pause in forced mode");
    chk(rises, senses, "R6 no cancel in forced mode");
    chk(g_out, 0, "R6 no grant during forced write");
    forced_mode = 1'b0; cancel_en = 1'b0;
    wait_quiet();
    chk(pend, 0, "R8 reads served after forced write");
  endtask

  task automatic t_stuck();
    stuck = 4'b0100;
    start_wr(pack4(2, 1, 5, 3));
    wait_done("R7 stuck");
    chk(int'(wr_err), 1, "R7 error flag on stuck cell");
    chk(senses, MAX_ITER, "R7 stops at iteration limit");
    chk(pulses[0], 2, "R2 healthy cell stops when matched");
    stuck = '0;
  endtask

  task automatic t_idle_read();
    @(negedge clk);
    chk(int'(paused), 0, "R8 idle not paused");
    push_rd(1);
    chk(int'(rd_grant), 1, "R8 idle grant follows request");
    wait_quiet();
    chk(pend, 0, "R8 idle read served");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_zero();
    t_pause();
    t_cap();
    t_cancel();
    t_forced();
    t_stuck();
    t_idle_read();
    summary_and_end();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary_and_end();
  end
endmodule